// File: doc/BRIEF.md
# Bidirectional Port Bank

This block is a bank of ten small parallel ports placed behind a plain address and data register interface. Every port keeps an output latch, a direction bit for each pin and a pull-up enable for the whole port. A few ports can also switch each pin between a push-pull and an open-drain driver. On the pad side, every pin has a drive value, a drive enable and a pull-up request. Each pin's input level is captured in a register on every clock.

An access carries a size: a single bit, one port (a nibble), or a pair of ports read or written together as a byte. A read returns, for each pin, the latch when the pin is an output and the captured pin level when it is an input. A write always lands in the latch, but it reaches the pad only while the pin is an output. A single-bit write is a read-modify-write of the whole port. The untouched bits of an input pin therefore take the pin level that was read. Direction, open-drain and pull-up settings are written through their own address pages on the same bus, one cycle per write. Reads are combinational from the stored state.

Top module: `pbank_top`

## Requirements
- R1: After reset every pin is an input, every latch holds 0, open-drain is off and every pull-up is off, so pin_out, pin_oe and pin_pu are all 0.
- R2: Each port p (0 to 9) has four pages. Data is at 0xFF0+p, direction at 0xFE0+p, open-drain at 0xFD0+p and pull-up at 0xFC0+p, where pull-up uses wdata bit 0. Configuration writes take wdata[3:0] whatever the size. Any other address is ignored on write and reads as 0.
- R3: A read returns, for each pin, the latch bit if the direction bit is 1 (output) and otherwise the pin level captured at the previous clock edge.
- R4: A nibble write loads the port latch. Pin p*4+i shows the latch bit on pin_out with pin_oe=1 only when its direction bit is 1. Otherwise pin_out and pin_oe are 0.
- R5: A bit write (size 0) selects the bit with bus_bit and takes its value from wdata[0]. The other latch bits of that port are loaded from the value a read of the port returns in that cycle.
- R6: Byte access (size 2) is valid only at 0xFF4, 0xFF6 and 0xFF8. The data bits [3:0] belong to the even port and bits [7:4] to the next port. A byte access at any other address is ignored and reads 0.
- R7: Port 1 is input-only. It never drives a pin, ignores direction writes, and always reads its pin levels.
- R8: Port 2 has three pins. Its fourth pad position never drives and never requests a pull-up, and it reads as 0.
- R9: Open-drain is available on ports 0, 2 and 3. An output pin in open-drain mode drives 0 (pin_oe=1) when its latch bit is 0 and releases (pin_oe=0) when it is 1. Open-drain writes to other ports have no effect.
- R10: pin_pu for a pin equals its port's pull-up enable while the pin is an input, and it is 0 while the pin is an output.
- R11: The size encoding is 0 for bit, 1 for nibble, 2 for byte, and 3 is invalid. A data-page write with size 3 is ignored, and a read with size 3 returns 0. A bit read returns the selected bit in rdata[0] and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Access address |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_size | input | 2 | Access size: 0 bit, 1 nibble, 2 byte |
| bus_bit | input | 2 | Bit select for single-bit access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 40 | Pin levels, four per port |
| pin_out | output | 40 | Drive value per pin |
| pin_oe | output | 40 | Drive enable per pin |
| pin_pu | output | 40 | Pull-up request per pin |

## Verification
A corrupted latch or direction bit shows up on pin_out or pin_oe in the cycle after the write that caused it. It also shows up at once on bus_rdata for any output pin. A wrong captured input level is hidden until the next read or single-bit write of that port. With a bit write, the fault is copied into the latch and becomes visible on the pad as soon as the pin turns into an output. The bench compares the pads and the read data against a behavioural model on every clock. Directed steps force each of these paths to become observable.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
   typedef enum logic [1:0] {
      SZ_BIT  = 2'd0,
      SZ_NIB  = 2'd1,
      SZ_BYTE = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;
endpackage

// File: rtl/pbank_port.sv
module pbank_port #(
   parameter int NIB_W   = 4,
   parameter int PIN_W   = 4,
   parameter bit HAS_OD  = 1'b0,
   parameter bit IN_ONLY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lat_we,
   input  logic [NIB_W-1:0] lat_d,
   input  logic             dir_we,
   input  logic             od_we,
   input  logic             pu_we,
   input  logic [NIB_W-1:0] cfg_d,
   input  logic [NIB_W-1:0] pad_in,
   output logic [NIB_W-1:0] rd_val,
   output logic [NIB_W-1:0] pad_out,
   output logic [NIB_W-1:0] pad_oe,
   output logic [NIB_W-1:0] pad_pu
);
   localparam logic [NIB_W-1:0] PIN_MASK = NIB_W'((1 << PIN_W) - 1);

   logic [NIB_W-1:0] lat_q, dir_q, od_q, in_q;
   logic             pu_q;

   // captured pin levels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_q <= '0;
      else        in_q <= pad_in & PIN_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pu_q <= 1'b0;
      else if (pu_we) pu_q <= cfg_d[0];
   end

   generate
      if (IN_ONLY) begin : g_in_only
         logic unused_wr;
         assign unused_wr = lat_we ^ dir_we ^ (^lat_d);
         assign lat_q = '0;
         assign dir_q = '0;
      end else begin : g_bidir
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lat_q <= '0;
               dir_q <= '0;
            end else begin
               if (lat_we) lat_q <= lat_d & PIN_MASK;
               if (dir_we) dir_q <= cfg_d & PIN_MASK;
            end
         end
      end

      if (HAS_OD) begin : g_od
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     od_q <= '0;
            else if (od_we) od_q <= cfg_d & PIN_MASK;
         end
      end else begin : g_no_od
         logic unused_od;
         assign unused_od = od_we;
         assign od_q = '0;
      end
   endgenerate

   always_comb begin
      rd_val  = ((dir_q & lat_q) | (~dir_q & in_q)) & PIN_MASK;
      pad_out = dir_q & lat_q & ~od_q;
      pad_oe  = dir_q & ~(od_q & lat_q);
      pad_pu  = {NIB_W{pu_q}} & ~dir_q & PIN_MASK;
   end
endmodule

// File: rtl/pbank_decode.sv
module pbank_decode
   import pbank_pkg::*;
#(
   parameter int          NUM_PORTS = 10,
   parameter int          NIB_W     = 4,
   parameter int          ADDR_W    = 12,
   parameter int          DATA_PAGE = 'hFF,
   parameter int          DIR_PAGE  = 'hFE,
   parameter int          OD_PAGE   = 'hFD,
   parameter int          PU_PAGE   = 'hFC,
   parameter logic [15:0] PAIR_MASK = 16'h0150,
   localparam int         BIT_W     = $clog2(NIB_W),
   localparam int         PG_W      = ADDR_W - 4
) (
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic                               bus_wr,
   input  logic [1:0]                         bus_size,
   input  logic [BIT_W-1:0]                   bus_bit,
   input  logic [2*NIB_W-1:0]                 bus_wdata,
   input  logic [NUM_PORTS-1:0][NIB_W-1:0]    port_rd,
   output logic [NUM_PORTS-1:0]               lat_we,
   output logic [NUM_PORTS-1:0][NIB_W-1:0]    lat_d,
   output logic [NUM_PORTS-1:0]               dir_we,
   output logic [NUM_PORTS-1:0]               od_we,
   output logic [NUM_PORTS-1:0]               pu_we,
   output logic [NIB_W-1:0]                   cfg_d
);
   logic [PG_W-1:0]  page;
   int               idx;
   acc_size_e        sz;
   logic [NIB_W-1:0] rmw;

   assign page  = bus_addr[ADDR_W-1:4];
   assign idx   = int'(bus_addr[3:0]);
   assign sz    = acc_size_e'(bus_size);
   assign cfg_d = bus_wdata[NIB_W-1:0];

   always_comb begin
      lat_we = '0;
      lat_d  = '0;
      dir_we = '0;
      od_we  = '0;
      pu_we  = '0;
      rmw    = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (bus_wr && page == PG_W'(DATA_PAGE)) begin
            if (sz == SZ_NIB && idx == p) begin
               lat_we[p] = 1'b1;
               lat_d[p]  = bus_wdata[NIB_W-1:0];
            end else if (sz == SZ_BIT && idx == p) begin
               rmw          = port_rd[p];
               rmw[bus_bit] = bus_wdata[0];
               lat_we[p]    = 1'b1;
               lat_d[p]     = rmw;
            end else if (sz == SZ_BYTE && PAIR_MASK[idx] && idx == p) begin
               lat_we[p] = 1'b1;
               lat_d[p]  = bus_wdata[NIB_W-1:0];
            end else if (sz == SZ_BYTE && PAIR_MASK[idx] && idx + 1 == p) begin
               lat_we[p] = 1'b1;
               lat_d[p]  = bus_wdata[2*NIB_W-1:NIB_W];
            end
         end
         dir_we[p] = bus_wr && page == PG_W'(DIR_PAGE) && idx == p;
         od_we[p]  = bus_wr && page == PG_W'(OD_PAGE)  && idx == p;
         pu_we[p]  = bus_wr && page == PG_W'(PU_PAGE)  && idx == p;
      end
   end
endmodule

// File: rtl/pbank_rdmux.sv
module pbank_rdmux
   import pbank_pkg::*;
#(
   parameter int          NUM_PORTS = 10,
   parameter int          NIB_W     = 4,
   parameter int          ADDR_W    = 12,
   parameter int          DATA_PAGE = 'hFF,
   parameter logic [15:0] PAIR_MASK = 16'h0150,
   localparam int         BIT_W     = $clog2(NIB_W),
   localparam int         PG_W      = ADDR_W - 4
) (
   input  logic [ADDR_W-1:0]               bus_addr,
   input  logic [1:0]                      bus_size,
   input  logic [BIT_W-1:0]                bus_bit,
   input  logic [NUM_PORTS-1:0][NIB_W-1:0] port_rd,
   output logic [2*NIB_W-1:0]              bus_rdata
);
   int        idx;
   acc_size_e sz;
   logic      hit;

   assign idx = int'(bus_addr[3:0]);
   assign sz  = acc_size_e'(bus_size);
   assign hit = (bus_addr[ADDR_W-1:4] == PG_W'(DATA_PAGE)) && (idx < NUM_PORTS);

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sz)
            SZ_BIT:  bus_rdata[0] = port_rd[idx][bus_bit];
            SZ_NIB:  bus_rdata[NIB_W-1:0] = port_rd[idx];
            SZ_BYTE: if (PAIR_MASK[idx]) bus_rdata = {port_rd[idx+1], port_rd[idx]};
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/pbank_top.sv
module pbank_top #(
   parameter int          NUM_PORTS    = 10,
   parameter int          NIB_W        = 4,
   parameter int          ADDR_W       = 12,
   parameter int          DATA_PAGE    = 'hFF,
   parameter int          DIR_PAGE     = 'hFE,
   parameter int          OD_PAGE      = 'hFD,
   parameter int          PU_PAGE      = 'hFC,
   parameter logic [15:0] OD_MASK      = 16'h000D,
   parameter logic [15:0] IN_ONLY_MASK = 16'h0002,
   parameter logic [15:0] PAIR_MASK    = 16'h0150,
   parameter logic [15:0] NARROW_MASK  = 16'h0004,
   parameter int          NARROW_W     = 3,
   localparam int         BIT_W        = $clog2(NIB_W),
   localparam int         PINS         = NUM_PORTS * NIB_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [1:0]          bus_size,
   input  logic [BIT_W-1:0]    bus_bit,
   input  logic [2*NIB_W-1:0]  bus_wdata,
   output logic [2*NIB_W-1:0]  bus_rdata,
   input  logic [PINS-1:0]     pin_in,
   output logic [PINS-1:0]     pin_out,
   output logic [PINS-1:0]     pin_oe,
   output logic [PINS-1:0]     pin_pu
);
   initial begin
      assert (NUM_PORTS >= 2 && NUM_PORTS <= 16)
         else $error("pbank_top: NUM_PORTS must lie in 2..16");
      assert (NIB_W >= 2 && (1 << BIT_W) == NIB_W)
         else $error("pbank_top: NIB_W must be a power of two");
      assert (ADDR_W > 4) else $error("pbank_top: ADDR_W too small");
      assert (NARROW_W >= 1 && NARROW_W <= NIB_W)
         else $error("pbank_top: NARROW_W out of range");
      assert ((PAIR_MASK >> (NUM_PORTS - 1)) == 0)
         else $error("pbank_top: a pair base leaves the bank");
   end

   logic [NUM_PORTS-1:0][NIB_W-1:0] port_rd, lat_d;
   logic [NUM_PORTS-1:0]            lat_we, dir_we, od_we, pu_we;
   logic [NIB_W-1:0]                cfg_d;

   pbank_decode #(
      .NUM_PORTS(NUM_PORTS), .NIB_W(NIB_W), .ADDR_W(ADDR_W),
      .DATA_PAGE(DATA_PAGE), .DIR_PAGE(DIR_PAGE), .OD_PAGE(OD_PAGE),
      .PU_PAGE(PU_PAGE), .PAIR_MASK(PAIR_MASK)
   ) u_decode (
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_size(bus_size),
      .bus_bit(bus_bit), .bus_wdata(bus_wdata), .port_rd(port_rd),
      .lat_we(lat_we), .lat_d(lat_d), .dir_we(dir_we), .od_we(od_we),
      .pu_we(pu_we), .cfg_d(cfg_d)
   );

   pbank_rdmux #(
      .NUM_PORTS(NUM_PORTS), .NIB_W(NIB_W), .ADDR_W(ADDR_W),
      .DATA_PAGE(DATA_PAGE), .PAIR_MASK(PAIR_MASK)
   ) u_rdmux (
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_bit(bus_bit),
      .port_rd(port_rd), .bus_rdata(bus_rdata)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         localparam int PW = NARROW_MASK[p] ? NARROW_W : NIB_W;
         pbank_port #(
            .NIB_W(NIB_W), .PIN_W(PW),
            .HAS_OD(OD_MASK[p]), .IN_ONLY(IN_ONLY_MASK[p])
         ) u_port (
            .clk(clk), .rst_n(rst_n),
            .lat_we(lat_we[p]), .lat_d(lat_d[p]),
            .dir_we(dir_we[p]), .od_we(od_we[p]), .pu_we(pu_we[p]),
            .cfg_d(cfg_d),
            .pad_in(pin_in[p*NIB_W +: NIB_W]),
            .rd_val(port_rd[p]),
            .pad_out(pin_out[p*NIB_W +: NIB_W]),
            .pad_oe(pin_oe[p*NIB_W +: NIB_W]),
            .pad_pu(pin_pu[p*NIB_W +: NIB_W])
         );
      end
   endgenerate
endmodule

// File: rtl/pbank_chk.sv
module pbank_chk #(
   parameter int          NUM_PORTS    = 10,
   parameter int          NIB_W        = 4,
   parameter int          ADDR_W       = 12,
   parameter int          DATA_PAGE    = 'hFF,
   parameter logic [15:0] IN_ONLY_MASK = 16'h0002,
   parameter logic [15:0] NARROW_MASK  = 16'h0004,
   parameter int          NARROW_W     = 3,
   localparam int         PINS         = NUM_PORTS * NIB_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [1:0]        bus_size,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic [PINS-1:0]   pin_pu
);
   // R1: first cycle out of reset shows the cleared pads
   a_r1_reset_pads_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && pin_pu == '0));

   // R10: no pull-up request on a driven pin
   a_r10_no_pullup_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0);

   // R4: pads only move after a bus write
   a_r4_pads_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_pu)));

   // R11: invalid size on the data page leaves the pads alone
   a_r11_bad_size_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size == 2'd3 && bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(DATA_PAGE))
      |=> ($stable(pin_out) && $stable(pin_oe)));

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
         if (IN_ONLY_MASK[p]) begin : g_in
            // R7: input-only port never drives
            a_r7_input_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
               pin_oe[p*NIB_W +: NIB_W] == '0);
         end
         if (NARROW_MASK[p] && NARROW_W < NIB_W) begin : g_nar
            // R8: missing pad positions stay idle
            a_r8_missing_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
               (pin_oe[p*NIB_W+NARROW_W +: NIB_W-NARROW_W] == '0) &&
               (pin_out[p*NIB_W+NARROW_W +: NIB_W-NARROW_W] == '0) &&
               (pin_pu[p*NIB_W+NARROW_W +: NIB_W-NARROW_W] == '0));
         end
      end
   endgenerate
endmodule

bind pbank_top pbank_chk #(
   .NUM_PORTS(NUM_PORTS), .NIB_W(NIB_W), .ADDR_W(ADDR_W),
   .DATA_PAGE(DATA_PAGE), .IN_ONLY_MASK(IN_ONLY_MASK),
   .NARROW_MASK(NARROW_MASK), .NARROW_W(NARROW_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_size(bus_size), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
);

// File: tb/pbank_top_bench.sv
module pbank_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_size = '0;
   logic [1:0]  bus_bit = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [39:0] pin_in = '0;
   logic [39:0] pin_out, pin_oe, pin_pu;

   int n_cmp = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pbank_top u_pbank_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_bit(bus_bit), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .pin_pu(pin_pu)
   );

   // behavioural reference state
   logic [3:0] m_lat [10];
   logic [3:0] m_dir [10];
   logic [3:0] m_od  [10];
   logic [3:0] m_in  [10];
   logic       m_pu  [10];

   function automatic logic [3:0] msk(int p);
      return (p == 2) ? 4'h7 : 4'hF;
   endfunction

   function automatic logic [3:0] rv(int p);
      return ((m_dir[p] & m_lat[p]) | (~m_dir[p] & m_in[p])) & msk(p);
   endfunction

   function automatic logic [7:0] exp_rd(logic [11:0] a, logic [1:0] sz, logic [1:0] b);
      int i = int'(a[3:0]);
      logic [3:0] v;
      if (a[11:4] != 8'hFF || i > 9) return 8'h00;
      v = rv(i);
      case (sz)
         2'd0: return {7'b0, v[b]};
         2'd1: return {4'b0, v};
         2'd2: return (i == 4 || i == 6 || i == 8) ? {rv(i + 1), v} : 8'h00;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_write();
      int i = int'(bus_addr[3:0]);
      logic [3:0] v;
      if (!bus_wr || i > 9) return;
      case (bus_addr[11:4])
         8'hFF: begin
            if (bus_size == 2'd1 && i != 1) m_lat[i] = bus_wdata[3:0] & msk(i);
            else if (bus_size == 2'd0 && i != 1) begin
               v = rv(i);
               v[bus_bit] = bus_wdata[0];
               m_lat[i] = v & msk(i);
            end else if (bus_size == 2'd2 && (i == 4 || i == 6 || i == 8)) begin
               m_lat[i]     = bus_wdata[3:0];
               m_lat[i + 1] = bus_wdata[7:4];
            end
         end
         8'hFE: if (i != 1) m_dir[i] = bus_wdata[3:0] & msk(i);
         8'hFD: if (i == 0 || i == 2 || i == 3) m_od[i] = bus_wdata[3:0] & msk(i);
         8'hFC: m_pu[i] = bus_wdata[0];
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < 10; p++) begin
            m_lat[p] = '0; m_dir[p] = '0; m_od[p] = '0; m_in[p] = '0; m_pu[p] = 1'b0;
         end
      end else begin
         model_write();
         for (int p = 0; p < 10; p++) m_in[p] = pin_in[p*4 +: 4] & msk(p);
      end
   end

   task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         logic [39:0] eo, ee, ep;
         for (int p = 0; p < 10; p++) begin
            eo[p*4 +: 4] = m_dir[p] & m_lat[p] & ~m_od[p];
            ee[p*4 +: 4] = m_dir[p] & ~(m_od[p] & m_lat[p]);
            ep[p*4 +: 4] = m_pu[p] ? (~m_dir[p] & msk(p)) : 4'h0;
         end
         chk("R3 rdata", {32'b0, bus_rdata}, {32'b0, exp_rd(bus_addr, bus_size, bus_bit)});
         chk("R4 pin_out", pin_out, eo);
         chk("R9 pin_oe", pin_oe, ee);
         chk("R10 pin_pu", pin_pu, ep);
      end
   end

   task automatic bus(logic [11:0] a, logic w, logic [1:0] sz, logic [1:0] b, logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wr = w; bus_size = sz; bus_bit = b; bus_wdata = d;
   endtask

   task automatic wr(logic [11:0] a, logic [1:0] sz, logic [1:0] b, logic [7:0] d);
      bus(a, 1'b1, sz, b, d);
   endtask

   task automatic rd_expect(string tag, logic [11:0] a, logic [1:0] sz, logic [1:0] b,
                            logic [7:0] exp);
      bus(a, 1'b0, sz, b, 8'h00);
      @(negedge clk);
      chk(tag, {32'b0, bus_rdata}, {32'b0, exp});
   endtask

   task automatic settle();
      bus(12'h000, 1'b0, 2'd1, 2'd0, 8'h00);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      #3 cmp_on = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      settle();
      chk("R1 oe", pin_oe, '0);
      chk("R1 pu", pin_pu, '0);
      rd_expect("R1 latch", 12'hFF0, 2'd1, 2'd0, 8'h00);
      // R3 input read
      pin_in[3:0] = 4'hA;
      rd_expect("R3 pin read", 12'hFF0, 2'd1, 2'd0, 8'h0A);
      // R4 drive on output pins only
      wr(12'hFE0, 2'd1, 2'd0, 8'h03);
      wr(12'hFF0, 2'd1, 2'd0, 8'h05);
      settle();
      chk("R4 out", {36'b0, pin_out[3:0]}, 40'h1);
      chk("R4 oe", {36'b0, pin_oe[3:0]}, 40'h3);
      rd_expect("R3 mixed read", 12'hFF0, 2'd1, 2'd0, 8'h09);
      // R5 bit write is read-modify-write
      wr(12'hFF0, 2'd0, 2'd1, 8'h00);
      wr(12'hFE0, 2'd1, 2'd0, 8'h0F);
      rd_expect("R5 rmw latch", 12'hFF0, 2'd1, 2'd0, 8'h09);
      // R6 byte pairs
      wr(12'hFE4, 2'd1, 2'd0, 8'h0F);
      wr(12'hFE5, 2'd1, 2'd0, 8'h0F);
      wr(12'hFF4, 2'd2, 2'd0, 8'hC3);
      rd_expect("R6 byte read", 12'hFF4, 2'd2, 2'd0, 8'hC3);
      chk("R6 byte pads", {32'b0, pin_out[23:16]}, 40'hC3);
      wr(12'hFF5, 2'd2, 2'd0, 8'hFF);
      rd_expect("R6 odd byte ignored", 12'hFF4, 2'd2, 2'd0, 8'hC3);
      rd_expect("R6 odd byte read", 12'hFF5, 2'd2, 2'd0, 8'h00);
      // R7 input-only port
      wr(12'hFE1, 2'd1, 2'd0, 8'h0F);
      pin_in[7:4] = 4'h6;
      wr(12'hFF1, 2'd1, 2'd0, 8'h09);
      rd_expect("R7 port1 read", 12'hFF1, 2'd1, 2'd0, 8'h06);
      chk("R7 port1 oe", {36'b0, pin_oe[7:4]}, 40'h0);
      // R8 narrow port
      wr(12'hFE2, 2'd1, 2'd0, 8'h0F);
      wr(12'hFF2, 2'd1, 2'd0, 8'h0F);
      rd_expect("R8 port2 read", 12'hFF2, 2'd1, 2'd0, 8'h07);
      chk("R8 port2 oe", {36'b0, pin_oe[11:8]}, 40'h7);
      // R9 open drain
      wr(12'hFD2, 2'd1, 2'd0, 8'h0F);
      wr(12'hFF2, 2'd1, 2'd0, 8'h05);
      settle();
      chk("R9 od oe", {36'b0, pin_oe[11:8]}, 40'h2);
      chk("R9 od out", {36'b0, pin_out[11:8]}, 40'h0);
      wr(12'hFD4, 2'd1, 2'd0, 8'h0F);
      settle();
      chk("R9 od ignored", {32'b0, pin_out[23:16]}, 40'hC3);
      // R10 pull-ups
      wr(12'hFC0, 2'd1, 2'd0, 8'h01);
      settle();
      chk("R10 pu on outputs", {36'b0, pin_pu[3:0]}, 40'h0);
      wr(12'hFE0, 2'd1, 2'd0, 8'h00);
      wr(12'hFC1, 2'd1, 2'd0, 8'h01);
      settle();
      chk("R10 pu port0", {36'b0, pin_pu[3:0]}, 40'hF);
      chk("R10 pu port1", {36'b0, pin_pu[7:4]}, 40'hF);
      // R11 size encoding, R2 address map
      wr(12'hFF4, 2'd3, 2'd0, 8'h00);
      rd_expect("R11 bit read", 12'hFF4, 2'd0, 2'd1, 8'h01);
      chk("R11 bad size ignored", {32'b0, pin_out[23:16]}, 40'hC3);
      rd_expect("R11 size3 read", 12'hFF4, 2'd3, 2'd0, 8'h00);
      wr(12'hFFA, 2'd1, 2'd0, 8'h0F);
      rd_expect("R2 unmapped port", 12'hFFA, 2'd1, 2'd0, 8'h00);
      rd_expect("R2 unmapped page", 12'hFB4, 2'd1, 2'd0, 8'h00);
      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         logic [7:0] pg;
         case ($urandom % 4)
            0: pg = 8'hFF;
            1: pg = 8'hFE;
            2: pg = 8'hFD;
            default: pg = 8'hFC;
         endcase
         pin_in = {8'($urandom), 32'($urandom)};
         bus({pg, 4'($urandom % 12)}, 1'($urandom), 2'($urandom), 2'($urandom),
             8'($urandom));
      end
      settle();
      settle();
      finish_run();
   end
endmodule